// File: doc/BRIEF.md
# Programmable debug trigger sequencer

This block is the event sequencer of an on-chip debug unit. It takes three single-cycle comparator match pulses, called M0, M1 and M2, and walks through three armed states, State1, State2 and State3, toward a terminal Final state. Entering Final raises a one-cycle trigger, which the debug unit can use as a breakpoint request. Each armed state has its own 4-bit control code. The code decides, for every match event, whether the sequencer stays where it is, moves forward, falls back to State1 or jumps straight to Final.

Software loads the three codes through a small write port while the sequencer is disarmed. It then raises the arm input. With suitable codes the block detects event orderings such as these:
- a routine ran twice without an intervening call to another routine;
- an event followed a marker before the clearing event arrived;
- an event occurred three times in a row with no reset event in between.

Dropping the arm input clears the sequence back to State1.

Top module: `dbg_seq_trigger`

## Requirements
- R1: After reset, state_o is 0 (State1) and trig_o is 0. All three codes are 0000, and that code holds every state for every match. state_o encodes 0=State1, 1=State2, 2=State3, 3=Final.
- R2: While arm_i is 0, the next state is State1 and trig_o is 0, whatever the matches are. Writes are accepted: wr_sel_i 0, 1 and 2 load the State1, State2 and State3 codes from wr_data_i.
- R3: A write made while arm_i is 1 is dropped, and the previously loaded code keeps steering the sequence.
- R4: State1 codes (match_i bit0=M0, bit1=M1, bit2=M2). 0001: M0 goes to State2. 0011: M1 goes to State2. 0010: M2 goes to State2. 0111: M0 or M1 goes to State2. State1 never moves to State3 or Final directly.
- R5: State2 code 1111 has bit 3 set and uses two-target mode: M0 or M1 goes to Final, and M2 returns to State1.
- R6: State2 code 0100: M2 goes to State3 and M1 returns to State1. State3 code 0010: M0 goes to Final and M1 returns to State1. Other matches hold the state.
- R7: State2 code 0011: M0 goes to Final, M1 returns to State1, M2 holds. This fires when M0 follows M2 before M1 does.
- R8: When several matches arrive in one cycle, the one with the highest priority among those that have a transition in the current state wins. M0 ranks highest, then M1, then M2. An armed cycle with no match holds the state.
- R9: A code that is not listed in R4 to R7 holds the current state for every match.
- R10: Final is sticky while armed. trig_o is high only in the first cycle in Final.
- R11: With M0 and M2 driven from one event and codes State1=0010, State2=0100, State3=0010, the third consecutive event with no M1 in between reaches Final.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | 1 = sequencer runs; 0 = held in State1, codes writable |
| match_i | input | 3 | Match pulses, bit0=M0, bit1=M1, bit2=M2 |
| wr_en_i | input | 1 | Code write strobe |
| wr_sel_i | input | 2 | Code select: 0=State1, 1=State2, 2=State3 |
| wr_data_i | input | 4 | Code value |
| state_o | output | 2 | Current sequencer state |
| trig_o | output | 1 | One-cycle trigger on entering Final |

## Verification
The bench builds the block with its default parameters: three armed states, 4-bit codes and three match inputs. This brings every decoded code of the table within reach, as well as every pairing of simultaneous matches and the tie of M0 to M2 that is used for counting. Under those defaults the scoreboard walks each listed scenario, the ordering checks and the no-effect cases cycle by cycle.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
    localparam int unsigned ARMED_N = 3;
    localparam int unsigned CODE_W  = 4;
    localparam int unsigned MATCH_N = 3;
    localparam int unsigned SEL_W   = $clog2(ARMED_N + 1);

    typedef enum logic [1:0] {
        SQ_ONE   = 2'd0,
        SQ_TWO   = 2'd1,
        SQ_THREE = 2'd2,
        SQ_DONE  = 2'd3
    } sq_state_e;

    typedef struct packed {
        logic      go;
        sq_state_e dst;
    } sq_move_t;

    typedef struct packed {
        sq_state_e st;
        logic      fire;
    } sq_regs_t;
endpackage

// File: rtl/dbg_seq_cfg.sv
module dbg_seq_cfg
    import dbg_seq_pkg::*;
#(
    parameter int unsigned N = ARMED_N,
    parameter int unsigned W = CODE_W,
    parameter int unsigned S = SEL_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              lock_i,
    input  logic              wr_en_i,
    input  logic [S-1:0]      wr_sel_i,
    input  logic [W-1:0]      wr_data_i,
    output logic [N-1:0][W-1:0] code_o
);
    logic [N-1:0][W-1:0] code_d, code_q;

    for (genvar g = 0; g < N; g++) begin : g_code
        always_comb begin
            code_d[g] = code_q[g];
            if (wr_en_i && !lock_i && (wr_sel_i == S'(g))) begin
                code_d[g] = wr_data_i;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                code_q[g] <= '0;
            end else begin
                code_q[g] <= code_d[g];
            end
        end
    end

    assign code_o = code_q;
endmodule

// File: rtl/dbg_seq_decode.sv
module dbg_seq_decode
    import dbg_seq_pkg::*;
#(
    parameter int unsigned W = CODE_W,
    parameter int unsigned M = MATCH_N
) (
    input  sq_state_e           cur_i,
    input  logic [W-1:0]        code_i,
    output sq_move_t [M-1:0]    mv_o
);
    localparam sq_move_t TO_ONE   = '{go: 1'b1, dst: SQ_ONE};
    localparam sq_move_t TO_TWO   = '{go: 1'b1, dst: SQ_TWO};
    localparam sq_move_t TO_THREE = '{go: 1'b1, dst: SQ_THREE};
    localparam sq_move_t TO_DONE  = '{go: 1'b1, dst: SQ_DONE};

    // Index 0 = M0, 1 = M1, 2 = M2. Unlisted codes leave every entry idle.
    always_comb begin
        mv_o = '0;
        case (cur_i)
            SQ_ONE: begin
                case (code_i)
                    4'b0001: mv_o[0] = TO_TWO;
                    4'b0011: mv_o[1] = TO_TWO;
                    4'b0010: mv_o[2] = TO_TWO;
                    4'b0111: begin
                        mv_o[0] = TO_TWO;
                        mv_o[1] = TO_TWO;
                    end
                    default: ;
                endcase
            end
            SQ_TWO: begin
                case (code_i)
                    4'b0100: begin
                        mv_o[1] = TO_ONE;
                        mv_o[2] = TO_THREE;
                    end
                    4'b0011: begin
                        mv_o[0] = TO_DONE;
                        mv_o[1] = TO_ONE;
                    end
                    4'b1111: begin
                        // bit 3: two-target mode, M0/M1 share one target
                        mv_o[0] = TO_DONE;
                        mv_o[1] = TO_DONE;
                        mv_o[2] = TO_ONE;
                    end
                    default: ;
                endcase
            end
            SQ_THREE: begin
                case (code_i)
                    4'b0010: begin
                        mv_o[0] = TO_DONE;
                        mv_o[1] = TO_ONE;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dbg_seq_pick.sv
module dbg_seq_pick
    import dbg_seq_pkg::*;
#(
    parameter int unsigned M = MATCH_N
) (
    input  logic [M-1:0]     hit_i,
    input  sq_move_t [M-1:0] mv_i,
    output logic             take_o,
    output sq_state_e        dst_o
);
    // Scan from lowest priority upward so the lowest index wins.
    always_comb begin
        take_o = 1'b0;
        dst_o  = SQ_ONE;
        for (int i = M - 1; i >= 0; i--) begin
            if (hit_i[i] && mv_i[i].go) begin
                take_o = 1'b1;
                dst_o  = mv_i[i].dst;
            end
        end
    end
endmodule

// File: rtl/dbg_seq_trigger.sv
module dbg_seq_trigger
    import dbg_seq_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               arm_i,
    input  logic [MATCH_N-1:0] match_i,
    input  logic               wr_en_i,
    input  logic [SEL_W-1:0]   wr_sel_i,
    input  logic [CODE_W-1:0]  wr_data_i,
    output logic [1:0]         state_o,
    output logic               trig_o
);
    logic [ARMED_N-1:0][CODE_W-1:0] codes;
    logic [CODE_W-1:0]              cur_code;
    sq_move_t [MATCH_N-1:0]         moves;
    logic                           take;
    sq_state_e                      dst;
    sq_regs_t                       r_d, r_q;

    dbg_seq_cfg #(.N(ARMED_N), .W(CODE_W), .S(SEL_W)) u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .lock_i    (arm_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .code_o    (codes)
    );

    always_comb begin
        cur_code = '0;
        if (r_q.st != SQ_DONE) begin
            cur_code = codes[r_q.st];
        end
    end

    dbg_seq_decode #(.W(CODE_W), .M(MATCH_N)) u_dec (
        .cur_i  (r_q.st),
        .code_i (cur_code),
        .mv_o   (moves)
    );

    dbg_seq_pick #(.M(MATCH_N)) u_pick (
        .hit_i  (match_i),
        .mv_i   (moves),
        .take_o (take),
        .dst_o  (dst)
    );

    always_comb begin
        r_d      = r_q;
        r_d.fire = 1'b0;
        if (!arm_i) begin
            r_d.st = SQ_ONE;
        end else if (r_q.st != SQ_DONE && take) begin
            r_d.st   = dst;
            r_d.fire = (dst == SQ_DONE);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: SQ_ONE, fire: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;
    assign trig_o  = r_q.fire;
endmodule

// File: rtl/dbg_seq_chk.sv
module dbg_seq_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       arm_i,
    input logic [2:0] match_i,
    input logic [1:0] state_o,
    input logic       trig_o
);
    AST_DISARM_HOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !arm_i |=> (state_o == 2'd0) && !trig_o); // R2

    AST_TRIG_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |=> !trig_o); // R10

    AST_TRIG_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |-> (state_o == 2'd3) && ($past(state_o) != 2'd3)); // R10

    AST_FINAL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm_i && state_o == 2'd3) |=> (state_o == 2'd3)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm_i && match_i == 3'b000) |=> $stable(state_o)); // R8

    AST_ONE_NO_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd0) |=> (state_o == 2'd0 || state_o == 2'd1)); // R4
endmodule

bind dbg_seq_trigger dbg_seq_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm_i),
    .match_i (match_i),
    .state_o (state_o),
    .trig_o  (trig_o)
);

// File: tb/sim_dbg_seq_trigger.sv
module sim_dbg_seq_trigger;
    localparam logic [1:0] S1 = 2'd0, S2 = 2'd1, S3 = 2'd2, FN = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm = 1'b0;
    logic [2:0] match = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [3:0] wr_data = '0;
    logic [1:0] state;
    logic       trig;

    int checks = 0;
    int errors = 0;

    logic [1:0] exp_st_q [$];
    logic       exp_tr_q [$];
    string      tag_q    [$];

    always #4 clk = ~clk; // 125 MHz

    dbg_seq_trigger u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .arm_i     (arm),
        .match_i   (match),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .state_o   (state),
        .trig_o    (trig)
    );

    // Driver: one cycle of stimulus, expected outcome after the next edge.
    task automatic step(input logic a, input logic [2:0] m,
                        input logic [1:0] est, input logic etr, input string tag);
        @(negedge clk);
        arm = a; match = m; wr_en = 1'b0;
        exp_st_q.push_back(est); exp_tr_q.push_back(etr); tag_q.push_back(tag);
    endtask

    task automatic wr(input logic a, input logic [1:0] sel, input logic [3:0] d,
                      input logic [1:0] est, input string tag);
        @(negedge clk);
        arm = a; match = '0; wr_en = 1'b1; wr_sel = sel; wr_data = d;
        exp_st_q.push_back(est); exp_tr_q.push_back(1'b0); tag_q.push_back(tag);
        @(negedge clk);
        wr_en = 1'b0;
        exp_st_q.push_back(est); exp_tr_q.push_back(1'b0); tag_q.push_back(tag);
    endtask

    task automatic load(input logic [3:0] c1, input logic [3:0] c2, input logic [3:0] c3);
        wr(1'b0, 2'd0, c1, S1, "R2 load");
        wr(1'b0, 2'd1, c2, S1, "R2 load");
        wr(1'b0, 2'd2, c3, S1, "R2 load");
    endtask

    // Monitor: compare after each rising edge.
    logic [1:0] m_st;
    logic       m_tr;
    string      m_tag;
    always @(posedge clk) begin
        #2;
        if (exp_st_q.size() > 0) begin
            m_st = exp_st_q.pop_front();
            m_tr = exp_tr_q.pop_front();
            m_tag = tag_q.pop_front();
            checks++;
            if (state !== m_st || trig !== m_tr) begin
                errors++;
                $display("FAIL %s: state=%0d trig=%0d expected state=%0d trig=%0d",
                         m_tag, state, trig, m_st, m_tr);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (state !== S1 || trig !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: state=%0d trig=%0d expected state=0 trig=0", state, trig);
        end
        rst_n = 1'b1;
        // R1: codes 0000 after reset hold State1
        step(1'b1, 3'b111, S1, 1'b0, "R1 reset codes hold");
        step(1'b1, 3'b100, S1, 1'b0, "R1 reset codes hold");

        // R4/R5: State1=0111, State2=1111
        load(4'b0111, 4'b1111, 4'b0000);
        step(1'b1, 3'b100, S1, 1'b0, "R4 M2 holds State1");
        step(1'b1, 3'b001, S2, 1'b0, "R4 M0 to State2");
        step(1'b1, 3'b100, S1, 1'b0, "R5 M2 back to State1");
        step(1'b1, 3'b010, S2, 1'b0, "R4 M1 to State2");
        step(1'b1, 3'b010, FN, 1'b1, "R5 M1 to Final");
        step(1'b1, 3'b100, FN, 1'b0, "R10 sticky, single pulse");
        step(1'b1, 3'b000, FN, 1'b0, "R10 sticky");
        step(1'b0, 3'b111, S1, 1'b0, "R2 disarm clears");
        step(1'b0, 3'b001, S1, 1'b0, "R2 matches ignored");

        // R3: armed writes dropped
        wr(1'b1, 2'd0, 4'b0000, S1, "R3 armed write");
        step(1'b1, 3'b001, S2, 1'b0, "R3 old State1 code kept");
        wr(1'b1, 2'd1, 4'b0000, S2, "R3 armed write");
        step(1'b1, 3'b001, FN, 1'b1, "R3 old State2 code kept");
        // R8: in two-target State2, M1 beats M2
        step(1'b0, 3'b000, S1, 1'b0, "R2 disarm");
        step(1'b1, 3'b001, S2, 1'b0, "R4 M0 to State2");
        step(1'b1, 3'b110, FN, 1'b1, "R8 M1 over M2");

        // R4 single-event codes
        step(1'b0, 3'b000, S1, 1'b0, "R2 disarm");
        load(4'b0001, 4'b0000, 4'b0000);
        step(1'b1, 3'b110, S1, 1'b0, "R4 0001 ignores M1/M2");
        step(1'b1, 3'b001, S2, 1'b0, "R4 0001 M0 to State2");
        step(1'b0, 3'b000, S1, 1'b0, "R2 disarm");
        load(4'b0011, 4'b0000, 4'b0000);
        step(1'b1, 3'b101, S1, 1'b0, "R4 0011 ignores M0/M2");
        step(1'b1, 3'b010, S2, 1'b0, "R4 0011 M1 to State2");

        // R6: State1=0010, State2=0100, State3=0010
        step(1'b0, 3'b000, S1, 1'b0, "R2 disarm");
        load(4'b0010, 4'b0100, 4'b0010);
        step(1'b1, 3'b011, S1, 1'b0, "R4 0010 ignores M0/M1");
        step(1'b1, 3'b100, S2, 1'b0, "R4 M2 to State2");
        step(1'b1, 3'b001, S2, 1'b0, "R6 M0 holds State2");
        step(1'b1, 3'b100, S3, 1'b0, "R6 M2 to State3");
        step(1'b1, 3'b010, S1, 1'b0, "R6 M1 resets from State3");
        step(1'b1, 3'b100, S2, 1'b0, "R4 M2 to State2");
        step(1'b1, 3'b110, S1, 1'b0, "R8 M1 over M2 in State2");
        step(1'b1, 3'b100, S2, 1'b0, "R4 M2 to State2");
        step(1'b1, 3'b100, S3, 1'b0, "R6 second M2");
        step(1'b1, 3'b100, S3, 1'b0, "R6 M2 holds State3");
        step(1'b1, 3'b011, FN, 1'b1, "R8 M0 over M1 to Final");

        // R11: M0 tied to M2, count three
        step(1'b0, 3'b000, S1, 1'b0, "R2 disarm");
        step(1'b1, 3'b101, S2, 1'b0, "R11 event 1");
        step(1'b1, 3'b010, S1, 1'b0, "R11 reset event");
        step(1'b1, 3'b101, S2, 1'b0, "R11 event 1");
        step(1'b1, 3'b101, S3, 1'b0, "R11 event 2");
        step(1'b1, 3'b000, S3, 1'b0, "R8 idle holds");
        step(1'b1, 3'b101, FN, 1'b1, "R11 event 3 fires");

        // R7: State1=0010, State2=0011
        step(1'b0, 3'b000, S1, 1'b0, "R2 disarm");
        load(4'b0010, 4'b0011, 4'b0000);
        step(1'b1, 3'b100, S2, 1'b0, "R7 M2 to State2");
        step(1'b1, 3'b100, S2, 1'b0, "R7 M2 holds");
        step(1'b1, 3'b010, S1, 1'b0, "R7 M1 clears");
        step(1'b1, 3'b100, S2, 1'b0, "R7 M2 to State2");
        step(1'b1, 3'b001, FN, 1'b1, "R7 M0 before M1 fires");

        // R9: unlisted codes hold
        step(1'b0, 3'b000, S1, 1'b0, "R2 disarm");
        load(4'b1010, 4'b0101, 4'b0000);
        step(1'b1, 3'b111, S1, 1'b0, "R9 unlisted State1 code");
        step(1'b0, 3'b000, S1, 1'b0, "R2 disarm");
        wr(1'b0, 2'd0, 4'b0111, S1, "R2 load");
        step(1'b1, 3'b001, S2, 1'b0, "R4 M0 to State2");
        step(1'b1, 3'b111, S2, 1'b0, "R9 unlisted State2 code");
        step(1'b1, 3'b001, S2, 1'b0, "R9 unlisted State2 code");

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule